// File: doc/BRIEF.md
# Serial single-error-correcting cyclic decoder

This block corrects one bit error in each 7-bit word of the cyclic (7,4) code whose generator is g(X) = 1 + X + X^3. The bits of a received word arrive one at a time, highest-order coefficient first, with a valid strobe. While they arrive, they are stored in a 7-stage buffer. At the same time, a 3-stage feedback divider forms the remainder of the received polynomial modulo g(X), which is the syndrome.

Once the seventh bit has been taken in, the block drains the buffer, one bit per cycle, for 7 cycles. A single comparator checks whether the current syndrome matches the syndrome of an error in the top position, X^6. If it matches, the bit leaving the buffer is inverted, and the same correction bit is fed back into the divider's input stage. Each drain cycle multiplies the syndrome by X modulo g(X). Together, these two actions let one comparator test every position in turn and cancel each correction it makes.

After the drain, the divider is cleared for the next word. If the divider held a nonzero remainder after the last drain step, a one-cycle residue flag is raised.

Top module: `meggitt_dec`

## Requirements
- R1: After reset, `dq_vld`, `dq_fix` and `dq_residue` are low and no received bits are counted.
- R2: A received word that is a codeword (remainder 0 modulo 1 + X + X^3) comes out bit-for-bit unchanged, with `dq_fix` low on all 7 output bits.
- R3: A codeword with exactly one bit inverted, at any of the 7 positions, comes out as the original codeword. `dq_fix` is high on exactly the one output cycle that carries the repaired coefficient.
- R4: `dq_vld` is high for exactly 7 consecutive cycles, starting in the cycle after the edge that accepts the seventh bit. The outputs carry coefficients X^6 down to X^0 in that order.
- R5: A bit is accepted only on an edge where `rx_vld` is high during the load phase. Idle cycles between bits do not change the result, and `dq_vld` stays low until 7 bits have been accepted.
- R6: While `dq_vld` is high, `rx_vld` and `rx_bit` are ignored. The next word's 7 bits are counted only from the first cycle after the drain.
- R7: The divider restarts from zero for each word, so words sent back to back decode independently.
- R8: `dq_residue` is high for one cycle, in the cycle after the last output bit, if and only if the divider remainder after the final drain step is nonzero. With the default code every nonzero syndrome is a single-error syndrome. So a word with two inverted bits yields exactly one `dq_fix`, a codeword at the output, and `dq_residue` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | Received bit present on `rx_bit` |
| rx_bit | input | 1 | Received serial bit, highest-order coefficient first |
| dq_vld | output | 1 | Corrected bit present on `dq_bit` (drain phase) |
| dq_bit | output | 1 | Corrected serial bit, highest-order coefficient first |
| dq_fix | output | 1 | The current output bit was inverted by the decoder |
| dq_residue | output | 1 | One-cycle pulse: nonzero syndrome remained after the drain |

## Verification
Clean codewords from several messages, including all-zero and all-one, show that a zero syndrome never triggers a correction. A single inversion swept over all seven positions shows that the comparator fires at the right shift for each position, and that the feedback leaves nothing behind for later bits. Words with idle gaps, words with input strobes during the drain, and words sent back to back separate the load-count and phase logic from the arithmetic. Double inversions exercise the miscorrection path and the residue flag.

// File: rtl/meggitt_pkg.sv
package meggitt_pkg;

   localparam int MAXR = 16;

   typedef enum logic {
      PH_LOAD  = 1'b0,
      PH_DRAIN = 1'b1
   } phase_t;

   // Remainder of X^p modulo g, where g has degree r (bit i = coefficient of X^i)
   function automatic logic [MAXR-1:0] xpow_mod(input int p, input int r,
                                                input logic [MAXR:0] g);
      logic [MAXR:0] s;
      s = '0;
      s[0] = 1'b1;
      for (int k = 0; k < p; k++) begin
         s = s << 1;
         if (s[r]) s = s ^ g;
      end
      return s[MAXR-1:0];
   endfunction

endpackage

// File: rtl/meggitt_syn.sv
module meggitt_syn #(
   parameter int         R    = 3,
   parameter logic [R:0] GPOL = 4'b1011
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         clr,
   input  logic         din,
   output logic [R-1:0] syn_q,
   output logic [R-1:0] syn_nxt
);

   logic fb;
   assign fb = syn_q[R-1];

   for (genvar i = 0; i < R; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign syn_nxt[0] = din ^ fb;
      end else if (GPOL[i]) begin : g_tap
         assign syn_nxt[i] = syn_q[i-1] ^ fb;
      end else begin : g_plain
         assign syn_nxt[i] = syn_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     syn_q <= '0;
      else if (clr)   syn_q <= '0;
      else if (shift) syn_q <= syn_nxt;
   end

endmodule

// File: rtl/meggitt_buf.sv
module meggitt_buf #(
   parameter int N = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift,
   input  logic din,
   output logic head
);

   logic [N-1:0] buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     buf_q <= '0;
      else if (shift) buf_q <= {buf_q[N-2:0], din};
   end

   assign head = buf_q[N-1];

endmodule

// File: rtl/meggitt_det.sv
module meggitt_det #(
   parameter int           R   = 3,
   parameter logic [R-1:0] PAT = 3'b101
) (
   input  logic [R-1:0] syn,
   output logic         hit
);

   logic [R-1:0] eq;

   for (genvar i = 0; i < R; i++) begin : g_cmp
      if (PAT[i]) begin : g_one
         assign eq[i] = syn[i];
      end else begin : g_zero
         assign eq[i] = ~syn[i];
      end
   end

   assign hit = &eq;

endmodule

// File: rtl/meggitt_dec.sv
module meggitt_dec
   import meggitt_pkg::*;
#(
   parameter int             N     = 7,
   parameter int             K     = 4,
   parameter logic [N-K:0]   GPOLY = 4'b1011
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_vld,
   input  logic rx_bit,
   output logic dq_vld,
   output logic dq_bit,
   output logic dq_fix,
   output logic dq_residue
);

   localparam int R  = N - K;
   localparam int CW = $clog2(N);
   localparam logic [CW-1:0] LAST = CW'(N - 1);
   localparam logic [MAXR-1:0] PAT_W = xpow_mod(N - 1, R, (MAXR+1)'(GPOLY));
   localparam logic [R-1:0]   PAT   = PAT_W[R-1:0];
   localparam logic [MAXR-1:0] WRAP = xpow_mod(N, R, (MAXR+1)'(GPOLY));

   if (K < 1 || R < 1 || R > MAXR) begin : g_bad_size
      $error("meggitt_dec: need 1 <= K < N and N-K <= %0d", MAXR);
   end
   if (!GPOLY[0] || !GPOLY[R]) begin : g_bad_poly
      $error("meggitt_dec: generator must have constant and top terms");
   end
   if (WRAP != MAXR'(1)) begin : g_not_cyclic
      $error("meggitt_dec: generator does not divide X^N + 1");
   end

   phase_t        ph_q;
   logic [CW-1:0] cnt_q;
   logic          resid_q;
   logic          load_en, drain, last;
   logic          hit, det, head;
   logic [R-1:0]  syn_q, syn_nxt;

   assign drain   = (ph_q == PH_DRAIN);
   assign load_en = (ph_q == PH_LOAD) && rx_vld;
   assign last    = (cnt_q == LAST);
   assign det     = drain & hit;

   meggitt_syn #(.R(R), .GPOL(GPOLY)) u_syn (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift   (load_en | drain),
      .clr     (drain & last),
      .din     (load_en ? rx_bit : det),
      .syn_q   (syn_q),
      .syn_nxt (syn_nxt)
   );

   meggitt_buf #(.N(N)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (load_en | drain),
      .din   (load_en & rx_bit),
      .head  (head)
   );

   meggitt_det #(.R(R), .PAT(PAT)) u_det (
      .syn (syn_q),
      .hit (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_LOAD;
         cnt_q   <= '0;
         resid_q <= 1'b0;
      end else begin
         resid_q <= 1'b0;
         if (load_en || drain) begin
            if (last) begin
               cnt_q <= '0;
               ph_q  <= drain ? PH_LOAD : PH_DRAIN;
               if (drain) resid_q <= |syn_nxt;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign dq_vld     = drain;
   assign dq_bit     = head ^ det;
   assign dq_fix     = det;
   assign dq_residue = resid_q;

endmodule

// File: rtl/meggitt_dec_chk.sv
module meggitt_dec_chk #(
   parameter int N = 7,
   parameter int R = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         rx_vld,
   input logic         dq_vld,
   input logic         dq_fix,
   input logic         dq_residue,
   input logic [R-1:0] syn_q
);

   localparam int CW = $clog2(N + 1) + 1;

   logic [CW-1:0] acc;
   logic [CW-1:0] vrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         vrun <= '0;
      end else begin
         if (dq_vld)      acc <= '0;
         else if (rx_vld) acc <= acc + 1'b1;
         vrun <= dq_vld ? vrun + 1'b1 : '0;
      end
   end

   p_fix_in_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dq_fix |-> dq_vld);

   p_drain_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_vld |-> (vrun < CW'(N)));

   p_drain_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_vld) |-> (vrun == CW'(N)));

   p_start_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_vld) |-> (acc == CW'(N)));

   p_syn_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_vld) |-> (syn_q == '0));

   p_residue_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dq_residue |-> $fell(dq_vld));

endmodule

bind meggitt_dec meggitt_dec_chk #(.N(N), .R(R)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_vld     (rx_vld),
   .dq_vld     (dq_vld),
   .dq_fix     (dq_fix),
   .dq_residue (dq_residue),
   .syn_q      (syn_q)
);

// File: tb/meggitt_dec_tb.sv
`timescale 1ns/1ps
module meggitt_dec_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_vld = 1'b0;
   logic rx_bit = 1'b0;
   logic dq_vld, dq_bit, dq_fix, dq_residue;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   meggitt_dec u_dut (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_bit(rx_bit),
      .dq_vld(dq_vld), .dq_bit(dq_bit), .dq_fix(dq_fix), .dq_residue(dq_residue)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // remainder of a 7-bit polynomial modulo 1 + X + X^3
   function automatic logic [2:0] rem7(input logic [6:0] w);
      logic [6:0] v = w;
      for (int i = 6; i >= 3; i--)
         if (v[i]) v = v ^ (7'b0001011 << (i - 3));
      return v[2:0];
   endfunction

   function automatic logic [6:0] enc(input logic [3:0] msg);
      logic [6:0] sh = {msg, 3'b000};
      return sh | {4'b0, rem7(sh)};
   endfunction

   // sends one word (X^6 first), collects the drained output
   task automatic run_block(input logic [6:0] w, input logic [6:0] gaps,
                            input bit noisy, output logic [6:0] got,
                            output logic [6:0] fixm, output bit resid);
      for (int i = 6; i >= 0; i--) begin
         if (gaps[i]) begin
            rx_vld = 1'b0;
            rx_bit = ~w[i];
            @(negedge clk);
            chk(!dq_vld, "R5 gap", dq_vld, 0);
         end
         rx_vld = 1'b1;
         rx_bit = w[i];
         @(negedge clk);
         if (i > 0) chk(!dq_vld, "R5 early", dq_vld, 0);
      end
      rx_vld = noisy;
      for (int j = 0; j < 7; j++) begin
         chk(dq_vld, "R4 drain", dq_vld, 1);
         got[6-j]  = dq_bit;
         fixm[6-j] = dq_fix;
         if (noisy) rx_bit = j[0];
         @(negedge clk);
      end
      rx_vld = 1'b0;
      chk(!dq_vld, "R4 end", dq_vld, 0);
      resid = dq_residue;
      @(negedge clk);
      chk(!dq_residue, "R8 pulse", dq_residue, 0);
   endtask

   task automatic t_reset();
      chk(!dq_vld && !dq_fix && !dq_residue, "R1",
          {dq_vld, dq_fix, dq_residue}, 0);
   endtask

   task automatic t_clean();
      logic [3:0] msgs [4] = '{4'h0, 4'hD, 4'hF, 4'h6};
      logic [6:0] g, f;
      bit r;
      for (int m = 0; m < 4; m++) begin
         run_block(enc(msgs[m]), 7'h00, 1'b0, g, f, r);
         chk(g == enc(msgs[m]), "R2 data", g, enc(msgs[m]));
         chk(f == 7'h00, "R2 fix", f, 0);
         chk(!r, "R8 clean", r, 0);
      end
   endtask

   task automatic t_single();
      logic [6:0] g, f, cw;
      bit r;
      for (int m = 0; m < 2; m++) begin
         cw = enc(m == 0 ? 4'hD : 4'h3);
         for (int p = 0; p < 7; p++) begin
            run_block(cw ^ (7'h01 << p), 7'h00, 1'b0, g, f, r);
            chk(g == cw, "R3 data", g, cw);
            chk(f == (7'h01 << p), "R3 fixpos", f, 7'h01 << p);
            chk(!r, "R8 single", r, 0);
         end
      end
   endtask

   task automatic t_gaps();
      logic [6:0] g, f, cw;
      bit r;
      cw = enc(4'hA);
      run_block(cw ^ 7'h08, 7'b1010011, 1'b0, g, f, r);
      chk(g == cw, "R5 gapped data", g, cw);
      chk(f == 7'h08, "R5 gapped fix", f, 7'h08);
   endtask

   task automatic t_ignore();
      logic [6:0] g, f, cw;
      bit r;
      cw = enc(4'h5);
      run_block(cw ^ 7'h40, 7'h00, 1'b1, g, f, r);
      chk(g == cw, "R6 first", g, cw);
      cw = enc(4'h9);
      run_block(cw ^ 7'h02, 7'h00, 1'b0, g, f, r);
      chk(g == cw, "R6 next data", g, cw);
      chk(f == 7'h02, "R6 next fix", f, 7'h02);
   endtask

   task automatic t_b2b();
      logic [6:0] g, f, cw;
      bit r;
      cw = enc(4'hE);
      run_block(cw ^ 7'h10, 7'h00, 1'b0, g, f, r);
      run_block(cw, 7'h00, 1'b0, g, f, r);
      chk(g == cw && f == 7'h00, "R7 b2b", g, cw);
   endtask

   task automatic t_double();
      logic [6:0] g, f, cw;
      bit r;
      cw = enc(4'hD);
      run_block(cw ^ 7'h41, 7'h00, 1'b0, g, f, r);
      chk($countones(f) == 1, "R8 one fix", $countones(f), 1);
      chk(rem7(g) == 3'b000 && g != cw, "R8 miscorrect", g, cw);
      chk(!r, "R8 residue", r, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_single();
      t_gaps();
      t_ignore();
      t_b2b();
      t_double();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule